// File: doc/BRIEF.md
# Debounced Key Matrix Scanner

This block reads a key matrix of up to six drive lines and five return lines, up to thirty keys in all. While idle it drives a standby pattern on the drive lines. When any return line goes high, it starts a scan. A scan takes a fixed number of oscillator ticks. In that time each drive line is raised alone twice, once in each of two passes, and the return lines are captured at the end of every window. The scan is accepted only when both passes give the same non-empty picture. The picture is then latched into the key buffer and a pending flag is raised. The flag pulls an active-low interrupt line low.

While the flag is set, no further scan can start. The host reads the buffer over its own serial path and signals that it is finished with a one-cycle read-done pulse. That pulse clears the flag. A two-bit segment-use setting removes the first drive line, or the first two, from the matrix. A removed line is held low and its key bits always read zero.

A two-bit sleep setting chooses which drive lines idle high. In sleep the oscillator request is low while idle. A press on a high-idling line wakes the oscillator for exactly one scan. A press on a low-idling line cannot start anything.

Top module: `keymatrix_scanner`

## Requirements
- R1: A key on drive line L (0-based) and return line r sets bit L*RETURNS + r of `key_buf`. Bit 0 is line 0 with return 0.
- R2: A scan lasts exactly 2*LINES*SLOT_TICKS + GAP_TICKS enabled oscillator ticks. In sleep, `osc_run` is high for exactly that many cycles when `osc_tick` is held high.
- R3: During a scan at most one drive line is high at a time. The returns are captured in two passes. If the two captures differ, nothing is stored and `key_pending` stays low.
- R4: After a failed comparison, a key that is still held restarts scanning at once, and scanning repeats until the two passes agree.
- R5: When the two captures agree and are non-zero, they are written to `key_buf`, `key_pending` goes high and `irq_n` goes low. `key_buf` changes at no other time except reset.
- R6: While `key_pending` is high, no scan starts and `key_buf` holds. A `buf_read` pulse clears `key_pending`, and a key that is still held is then scanned anew.
- R7: `seg_mode` 00 uses all lines. 01 removes line 0. 10 and 11 remove lines 0 and 1. A removed line stays low and contributes no key bits.
- R8: `sleep_mode` 00 is normal operation: all enabled lines idle high and `osc_run` stays high. In sleep, the lines that idle high are: 01 the top line only, 10 the top two lines, 11 all enabled lines. `osc_run` is low while idle.
- R9: In sleep, a press on a line that idles low starts no scan and leaves `osc_run` low.
- R10: Two captures that agree but are both empty store nothing and raise no flag.
- R11: Reset, active low and asynchronous, clears `key_buf` and `key_pending` and makes `irq_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Oscillator tick; a scan advances only on ticks |
| seg_mode | input | 2 | Drive-line removal setting |
| sleep_mode | input | 2 | Normal (00) or one of three sleep standby patterns |
| ret_in | input | RETURNS | Matrix return lines |
| buf_read | input | 1 | One-cycle pulse: host finished reading the buffer |
| scan_out | output | LINES | Matrix drive lines |
| osc_run | output | 1 | Oscillator request |
| key_buf | output | LINES*RETURNS | Accepted key picture |
| key_pending | output | 1 | Buffer holds unread data |
| irq_n | output | 1 | Active-low key interrupt |

## Verification
The assertions rely on `buf_read` arriving only as a single-cycle pulse. They also rely on the mode inputs staying constant while a scan is running. The bench changes `seg_mode` and `sleep_mode` only when the block is idle with no flag pending, and pulses `buf_read` once per read. The return lines come from a matrix model in the bench that responds to `scan_out`. Press changes that are meant to land inside a scan are timed against the known slot schedule, so each such change falls in a chosen pass.

// File: rtl/kscan_pkg.sv
package kscan_pkg;

   typedef enum logic [1:0] {
      SLP_NONE = 2'b00,
      SLP_TOP1 = 2'b01,
      SLP_TOP2 = 2'b10,
      SLP_ALL  = 2'b11
   } sleep_sel_e;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/kscan_lines.sv
module kscan_lines
   import kscan_pkg::*;
#(
   parameter int LINES = 6
) (
   input  logic [1:0]       seg_mode,
   input  logic [1:0]       sleep_mode,
   input  logic             busy,
   input  logic             drive_en,
   input  logic [LINES-1:0] drive_line,
   output logic [LINES-1:0] en_mask,
   output logic [LINES-1:0] scan_out
);

   generate
      if (LINES < 3) begin : g_bad_lines
         $error("kscan_lines: LINES must be at least 3");
      end
      for (genvar i = 0; i < LINES; i++) begin : g_line
         localparam bit IS_TOP  = (i == LINES - 1);
         localparam bit IS_TOP2 = (i >= LINES - 2);
         logic hi_idle;

         if (i == 0) begin : g_first
            assign en_mask[i] = (seg_mode == 2'b00);
         end else if (i == 1) begin : g_second
            assign en_mask[i] = ~seg_mode[1];
         end else begin : g_fixed
            assign en_mask[i] = 1'b1;
         end

         always_comb begin
            case (sleep_sel_e'(sleep_mode))
               SLP_TOP1: hi_idle = IS_TOP;
               SLP_TOP2: hi_idle = IS_TOP2;
               default:  hi_idle = 1'b1;
            endcase
         end

         assign scan_out[i] = en_mask[i] &
                              (busy ? (drive_en & drive_line[i]) : hi_idle);
      end
   endgenerate

endmodule

// File: rtl/kscan_seq.sv
module kscan_seq
   import kscan_pkg::*;
#(
   parameter int LINES      = 6,
   parameter int SLOT_TICKS = 48,
   parameter int GAP_TICKS  = 6
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                osc_tick,
   input  logic                                start,
   output logic                                busy,
   output logic                                drive_en,
   output logic [LINES-1:0]                    drive_line,
   output logic                                sample_stb,
   output logic                                sample_pass,
   output logic [cnt_width(LINES)-1:0]         sample_line,
   output logic                                done
);

   localparam int SUB_W  = cnt_width(SLOT_TICKS);
   localparam int LINE_W = cnt_width(LINES);
   localparam int GAP_W  = cnt_width(GAP_TICKS);

   generate
      if (SLOT_TICKS < 1 || GAP_TICKS < 1) begin : g_bad_timing
         $error("kscan_seq: SLOT_TICKS and GAP_TICKS must be at least 1");
      end
   endgenerate

   logic [SUB_W-1:0]  sub_cnt;
   logic [LINE_W-1:0] line_idx;
   logic [GAP_W-1:0]  gap_cnt;
   logic              pass_q;
   logic              in_gap;
   logic              tick;
   logic              slot_end;
   logic              line_last;
   logic              gap_last;

   assign tick      = osc_tick & busy;
   assign slot_end  = (sub_cnt == SUB_W'(SLOT_TICKS - 1));
   assign line_last = (line_idx == LINE_W'(LINES - 1));
   assign gap_last  = (gap_cnt == GAP_W'(GAP_TICKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         sub_cnt  <= '0;
         line_idx <= '0;
         gap_cnt  <= '0;
         pass_q   <= 1'b0;
         in_gap   <= 1'b0;
      end else if (!busy) begin
         if (start) begin
            busy     <= 1'b1;
            sub_cnt  <= '0;
            line_idx <= '0;
            gap_cnt  <= '0;
            pass_q   <= 1'b0;
            in_gap   <= 1'b0;
         end
      end else if (tick) begin
         if (in_gap) begin
            if (gap_last) begin
               busy <= 1'b0;
            end else begin
               gap_cnt <= gap_cnt + 1'b1;
            end
         end else if (slot_end) begin
            sub_cnt <= '0;
            if (line_last) begin
               line_idx <= '0;
               if (pass_q) begin
                  in_gap <= 1'b1;
               end else begin
                  pass_q <= 1'b1;
               end
            end else begin
               line_idx <= line_idx + 1'b1;
            end
         end else begin
            sub_cnt <= sub_cnt + 1'b1;
         end
      end
   end

   generate
      for (genvar i = 0; i < LINES; i++) begin : g_drive
         assign drive_line[i] = (line_idx == LINE_W'(i));
      end
   endgenerate

   assign drive_en    = busy & ~in_gap;
   assign sample_stb  = tick & ~in_gap & slot_end;
   assign sample_pass = pass_q;
   assign sample_line = line_idx;
   assign done        = tick & in_gap & gap_last;

   // R2
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   // R2
   gap_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

endmodule

// File: rtl/kscan_capture.sv
module kscan_capture
   import kscan_pkg::*;
#(
   parameter int LINES   = 6,
   parameter int RETURNS = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clear,
   input  logic                        sample_stb,
   input  logic                        sample_pass,
   input  logic [cnt_width(LINES)-1:0] sample_line,
   input  logic [LINES-1:0]            en_mask,
   input  logic [RETURNS-1:0]          ret_in,
   input  logic                        done,
   input  logic                        buf_read,
   output logic [LINES*RETURNS-1:0]    key_buf,
   output logic                        pending
);

   localparam int LINE_W = cnt_width(LINES);
   localparam int NKEYS  = LINES * RETURNS;

   logic [RETURNS-1:0] cap_a [LINES];
   logic [RETURNS-1:0] cap_b [LINES];
   logic [NKEYS-1:0]   flat_a;
   logic [NKEYS-1:0]   flat_b;
   logic               agree;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int l = 0; l < LINES; l++) begin
            cap_a[l] <= '0;
            cap_b[l] <= '0;
         end
      end else if (clear) begin
         for (int l = 0; l < LINES; l++) begin
            cap_a[l] <= '0;
            cap_b[l] <= '0;
         end
      end else if (sample_stb) begin
         for (int l = 0; l < LINES; l++) begin
            if (sample_line == LINE_W'(l)) begin
               if (sample_pass) begin
                  cap_b[l] <= ret_in & {RETURNS{en_mask[l]}};
               end else begin
                  cap_a[l] <= ret_in & {RETURNS{en_mask[l]}};
               end
            end
         end
      end
   end

   generate
      for (genvar l = 0; l < LINES; l++) begin : g_flat
         assign flat_a[l*RETURNS +: RETURNS] = cap_a[l];
         assign flat_b[l*RETURNS +: RETURNS] = cap_b[l];
      end
   endgenerate

   assign agree = (flat_a == flat_b) && (|flat_a);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_buf <= '0;
         pending <= 1'b0;
      end else if (done && agree) begin
         key_buf <= flat_a;
         pending <= 1'b1;
      end else if (buf_read) begin
         pending <= 1'b0;
      end
   end

   // R6
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !buf_read) |=> pending);

   // R5
   pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pending && !done) |=> !pending);

   // R5
   buf_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> $stable(key_buf));

endmodule

// File: rtl/keymatrix_scanner.sv
module keymatrix_scanner
   import kscan_pkg::*;
#(
   parameter int LINES      = 6,
   parameter int RETURNS    = 5,
   parameter int SLOT_TICKS = 48,
   parameter int GAP_TICKS  = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     osc_tick,
   input  logic [1:0]               seg_mode,
   input  logic [1:0]               sleep_mode,
   input  logic [RETURNS-1:0]       ret_in,
   input  logic                     buf_read,
   output logic [LINES-1:0]         scan_out,
   output logic                     osc_run,
   output logic [LINES*RETURNS-1:0] key_buf,
   output logic                     key_pending,
   output logic                     irq_n
);

   localparam int LINE_W = cnt_width(LINES);

   generate
      if (RETURNS < 1 || LINES * RETURNS > 64) begin : g_bad_size
         $error("keymatrix_scanner: matrix size out of range");
      end
   endgenerate

   logic              busy;
   logic              drive_en;
   logic              sample_stb;
   logic              sample_pass;
   logic              done;
   logic              start_req;
   logic [LINES-1:0]  drive_line;
   logic [LINES-1:0]  en_mask;
   logic [LINE_W-1:0] sample_line;

   assign start_req = (|ret_in) & ~key_pending & ~busy;
   assign osc_run   = (sleep_mode == SLP_NONE) | busy;
   assign irq_n     = ~key_pending;

   kscan_seq #(
      .LINES      (LINES),
      .SLOT_TICKS (SLOT_TICKS),
      .GAP_TICKS  (GAP_TICKS)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .osc_tick    (osc_tick),
      .start       (start_req),
      .busy        (busy),
      .drive_en    (drive_en),
      .drive_line  (drive_line),
      .sample_stb  (sample_stb),
      .sample_pass (sample_pass),
      .sample_line (sample_line),
      .done        (done)
   );

   kscan_lines #(
      .LINES (LINES)
   ) u_lines (
      .seg_mode   (seg_mode),
      .sleep_mode (sleep_mode),
      .busy       (busy),
      .drive_en   (drive_en),
      .drive_line (drive_line),
      .en_mask    (en_mask),
      .scan_out   (scan_out)
   );

   kscan_capture #(
      .LINES   (LINES),
      .RETURNS (RETURNS)
   ) u_cap (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (start_req),
      .sample_stb  (sample_stb),
      .sample_pass (sample_pass),
      .sample_line (sample_line),
      .en_mask     (en_mask),
      .ret_in      (ret_in),
      .done        (done),
      .buf_read    (buf_read),
      .key_buf     (key_buf),
      .pending     (key_pending)
   );

   // R6
   scan_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && key_pending) |=> !busy);

   // R3
   one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> $onehot0(scan_out));

endmodule

// File: tb/keymatrix_scanner_test.sv
module keymatrix_scanner_test;

   localparam int LINES = 6;
   localparam int RETS  = 5;
   localparam int NK    = LINES * RETS;
   localparam int SLOT  = 4;
   localparam int GAP   = 2;
   localparam int SCAN  = 2 * LINES * SLOT + GAP;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          osc_tick = 1'b1;
   logic [1:0]    seg_mode = 2'b00;
   logic [1:0]    sleep_mode = 2'b00;
   logic [RETS-1:0]  ret_in;
   logic          buf_read = 1'b0;
   logic [LINES-1:0] scan_out;
   logic          osc_run;
   logic [NK-1:0] key_buf;
   logic          key_pending;
   logic          irq_n;

   logic [NK-1:0] press = '0;
   bit            gate_rand = 1'b0;
   bit            finished = 1'b0;
   int            checks = 0;
   int            errors = 0;

   always #2.5 clk = ~clk;

   keymatrix_scanner #(
      .LINES (LINES), .RETURNS (RETS), .SLOT_TICKS (SLOT), .GAP_TICKS (GAP)
   ) uut (
      .clk (clk), .rst_n (rst_n), .osc_tick (osc_tick), .seg_mode (seg_mode),
      .sleep_mode (sleep_mode), .ret_in (ret_in), .buf_read (buf_read),
      .scan_out (scan_out), .osc_run (osc_run), .key_buf (key_buf),
      .key_pending (key_pending), .irq_n (irq_n)
   );

   // matrix model: return r is high when a driven line has key r pressed
   always_comb begin
      ret_in = '0;
      for (int l = 0; l < LINES; l++)
         for (int r = 0; r < RETS; r++)
            if (scan_out[l] && press[l*RETS + r]) ret_in[r] = 1'b1;
   end

   initial begin
      forever begin
         @(negedge clk);
         osc_tick = gate_rand ? (($urandom % 4) != 0) : 1'b1;
      end
   end

   function automatic logic [LINES-1:0] en_exp(input logic [1:0] seg);
      case (seg)
         2'b00:   return 6'h3F;
         2'b01:   return 6'h3E;
         default: return 6'h3C;
      endcase
   endfunction

   function automatic logic [LINES-1:0] idle_exp(input logic [1:0] seg, input logic [1:0] slp);
      logic [LINES-1:0] base;
      case (slp)
         2'b01:   base = 6'h20;
         2'b10:   base = 6'h30;
         default: base = 6'h3F;
      endcase
      return base & en_exp(seg);
   endfunction

   function automatic logic [NK-1:0] key_mask(input logic [1:0] seg);
      logic [NK-1:0] m = '0;
      logic [LINES-1:0] e = en_exp(seg);
      for (int l = 0; l < LINES; l++)
         if (e[l]) m[l*RETS +: RETS] = '1;
      return m;
   endfunction

   function automatic logic [NK-1:0] kbit(input int line, input int ret);
      logic [NK-1:0] v = '0;
      v[line*RETS + ret] = 1'b1;
      return v;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_pend(input int lim, output bit got);
      got = 1'b0;
      for (int i = 0; i < lim; i++) begin
         @(negedge clk);
         if (key_pending) begin
            got = 1'b1;
            break;
         end
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_read();
      @(negedge clk);
      buf_read = 1'b1;
      @(negedge clk);
      buf_read = 1'b0;
   endtask

   initial begin
      bit got;
      int cnt;
      logic [NK-1:0] exp_keys;
      void'($urandom(32'h5EED_4321));

      // R11 reset state
      wait_cyc(3);
      chk(key_pending == 1'b0 && irq_n == 1'b1, "R11 reset flag", {30'd0, key_pending, irq_n}, 32'h1);
      chk(key_buf == '0, "R11 reset buffer", 32'(key_buf), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R8 normal idle pattern
      chk(scan_out == 6'h3F && osc_run, "R8 normal idle", {25'd0, osc_run, scan_out}, 32'h7F);

      // R1 R5 single key line 2 return 3
      press = kbit(2, 3);
      wait_pend(400, got);
      chk(got && key_buf == kbit(2, 3), "R1 key index", 32'(key_buf), 32'(kbit(2, 3)));
      chk(irq_n == 1'b0, "R5 irq low", 32'(irq_n), 32'h0);

      // R6 lockout while pending
      press = kbit(4, 0);
      wait_cyc(200);
      chk(key_buf == kbit(2, 3) && key_pending, "R6 buffer locked", 32'(key_buf), 32'(kbit(2, 3)));
      chk(scan_out == 6'h3F, "R6 no scan while pending", 32'(scan_out), 32'h3F);
      do_read();
      chk(key_pending == 1'b0 && irq_n == 1'b1, "R6 read clears flag", 32'(key_pending), 32'h0);
      wait_pend(400, got);
      chk(got && key_buf == kbit(4, 0), "R6 rescan after read", 32'(key_buf), 32'(kbit(4, 0)));
      press = '0;
      do_read();
      wait_cyc(5);

      // R3 release during second pass -> mismatch, nothing stored
      press = kbit(1, 2);
      wait_cyc(26);
      press = '0;
      wait_cyc(150);
      chk(key_pending == 1'b0, "R3 mismatch not stored", 32'(key_pending), 32'h0);

      // R4 key added in second pass -> mismatch then rescan until equal
      press = kbit(1, 2);
      wait_cyc(26);
      press = kbit(1, 2) | kbit(5, 3);
      wait_pend(600, got);
      chk(got && key_buf == (kbit(1, 2) | kbit(5, 3)), "R4 rescan result", 32'(key_buf), 32'(kbit(1, 2) | kbit(5, 3)));
      press = '0;
      do_read();
      wait_cyc(5);

      // R10 key pressed only during idle check window, gone before both samples
      press = kbit(0, 0);
      @(negedge clk);
      press = '0;
      wait_cyc(150);
      chk(key_pending == 1'b0, "R10 empty agree stores nothing", 32'(key_pending), 32'h0);

      // R7 removed lines
      seg_mode = 2'b10;
      @(negedge clk);
      chk(scan_out == idle_exp(2'b10, 2'b00), "R7 idle with two removed", 32'(scan_out), 32'(idle_exp(2'b10, 2'b00)));
      press = kbit(0, 1);
      wait_cyc(150);
      chk(key_pending == 1'b0, "R7 removed line ignored", 32'(key_pending), 32'h0);
      press = kbit(0, 1) | kbit(3, 4);
      wait_pend(400, got);
      chk(got && key_buf == kbit(3, 4), "R7 removed bits zero", 32'(key_buf), 32'(kbit(3, 4)));
      press = '0;
      do_read();
      wait_cyc(5);
      seg_mode = 2'b00;

      // R8 sleep idle patterns
      for (int s = 1; s < 4; s++) begin
         sleep_mode = 2'(s);
         @(negedge clk);
         chk(scan_out == idle_exp(2'b00, 2'(s)) && !osc_run, "R8 sleep idle",
             {25'd0, osc_run, scan_out}, {25'd0, 1'b0, idle_exp(2'b00, 2'(s))});
      end

      // R9 sleep 01: key on low-idling line
      sleep_mode = 2'b01;
      press = kbit(0, 0);
      cnt = 0;
      for (int i = 0; i < 150; i++) begin
         @(negedge clk);
         if (osc_run) cnt++;
      end
      chk(cnt == 0 && !key_pending, "R9 low line no wake", 32'(cnt), 32'h0);

      // R2 sleep wake runs one scan of fixed length
      press = kbit(5, 0);
      @(negedge clk);
      cnt = 0;
      while (osc_run && cnt < 1000) begin
         cnt++;
         @(negedge clk);
      end
      chk(cnt == SCAN, "R2 scan length", 32'(cnt), 32'(SCAN));
      chk(key_pending && key_buf == kbit(5, 0), "R2 wake result", 32'(key_buf), 32'(kbit(5, 0)));
      press = '0;
      do_read();
      wait_cyc(5);
      sleep_mode = 2'b00;
      @(negedge clk);

      // random patterns with gated oscillator
      gate_rand = 1'b1;
      for (int it = 0; it < 20; it++) begin
         seg_mode = 2'($urandom % 4);
         exp_keys = NK'($urandom) & key_mask(seg_mode);
         if (exp_keys == '0) exp_keys = kbit(5, it % RETS);
         @(negedge clk);
         press = exp_keys;
         wait_pend(3000, got);
         chk(got && key_buf == exp_keys, "R1 R5 random picture", 32'(key_buf), 32'(exp_keys));
         press = '0;
         do_read();
         chk(!key_pending, "R6 random read clear", 32'(key_pending), 32'h0);
         wait_cyc(3);
      end
      gate_rand = 1'b0;
      seg_mode = 2'b00;

      // R11 reset while pending
      press = kbit(3, 3);
      wait_pend(400, got);
      press = '0;
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(!key_pending && key_buf == '0 && irq_n, "R11 reset clears", 32'(key_buf), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      wait_cyc(3);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      finished = 1'b1;
      $finish;
   end

   initial begin
      #(5ns * 150000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule